// File: doc/BRIEF.md
# FSK and DTMF Tone Synthesizer

This block generates the digital transmit waveform for a low-speed telephone modem. In FSK mode it converts a serial bit stream, whose timing is set by an external UART, into mark and space tones for either of two signalling standards (V.23 or Bell 202), each with a low and a high bit rate. In tone mode it produces any of the sixteen DTMF dual-tone pairs, or a single tone taken from the DTMF frequency set, chosen by a 4-bit code.

Each tone comes from a 24-bit phase accumulator that advances once per cycle of the 3.579545 MHz reference clock, and a quarter-wave sine table that is filled when the design is elaborated. The output is a signed two's-complement sample stream in which zero stands for mid-rail. Filtering, the DAC and line levels are handled downstream.

Top module: `tone_synth`

## Requirements
- R1: With `tone_mode`=0 and `bell_sel`=0, the tone is 390 Hz (mark, `tx_bit`=1) or 450 Hz (space) when `hi_rate`=0, and 1300 Hz (mark) or 2100 Hz (space) when `hi_rate`=1. The amplitude is 1800.
- R2: With `tone_mode`=0 and `bell_sel`=1, the tone is 387 Hz (mark) or 487 Hz (space) when `hi_rate`=0, and 1200 Hz (mark) or 2200 Hz (space) when `hi_rate`=1.
- R3: With `tone_mode`=0 and `fsk_en`=0, `sample_o` is exactly 0 from the fourth clock edge after the change onward.
- R4: With `tone_mode`=1 and `single_sel`=0, `sample_o` is the sum of a low tone with amplitude 1033 and a high tone with amplitude 1300. Codes 0 to 15 select the low/high pairs 941/1633, 697/1209, 697/1336, 697/1477, 770/1209, 770/1336, 770/1477, 852/1209, 852/1336, 852/1477, 941/1336, 941/1209, 941/1477, 697/1633, 770/1633 and 852/1633 Hz.
- R5: With `tone_mode`=1 and `single_sel`=1, a single tone of amplitude 1300 is produced. Codes 0 to 15 select 1633, 1209, 1336, 1477, 1209, 1336, 1477, 1209, 852, 852, 941, 941, 941, 697, 770 and 852 Hz.
- R6: With `tone_mode`=1 and `tone_en`=0, `sample_o` is exactly 0 from the fourth clock edge after the change onward. The tone resumes when `tone_en` returns to 1.
- R7: Each tone's phase is the sum of round(f x 2^24 / 3579545) taken once per clock. An input change takes effect in the increment from the second clock edge after it. Changing the FSK bit never restarts the phase. Within 48 LSB, `sample_o` follows amplitude x sin(2 pi x phase / 2^24).
- R8: The sum is saturated to +/-2047, so `sample_o` never takes the value -2048.
- R9: While reset is asserted, and on the first cycle after it is released, `sample_o` is 0, and every phase accumulator restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bell_sel | input | 1 | 0 selects V.23 frequencies, 1 selects Bell 202 frequencies |
| hi_rate | input | 1 | 0 selects the low-rate tone pair, 1 the 1200 bps pair |
| fsk_en | input | 1 | Enables the output in FSK mode |
| tx_bit | input | 1 | Serial bit to send: 1 is mark, 0 is space |
| tone_mode | input | 1 | 0 selects FSK, 1 selects DTMF or single tone |
| single_sel | input | 1 | In tone mode, 1 selects a single tone instead of a pair |
| tone_en | input | 1 | Enables the output in tone mode |
| tone_code | input | 4 | Tone selection code |
| sample_o | output | 12 | Signed output sample, 0 = mid-rail |

## Verification
The hardest effect to reach from the ports is phase continuity across bit changes. A restart of the phase leaves each individual tone looking correct, and it shows up only as an accumulated phase error against a long-running model. The stimulus therefore toggles `tx_bit` every few dozen cycles over thousands of cycles and compares each sample with a bench phase model that is never reset between bits. Saturation also needs both DTMF tones to peak together, so a long 941/1633 Hz run is watched on every cycle until clipping at +/-2047 is seen.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    AMP_SEL_FSK  = 2'd0,
    AMP_SEL_SGL  = 2'd1,
    AMP_SEL_DUAL = 2'd2
  } amp_sel_e;

  // phase increment for a tone of hz at clock clk_hz with ph_w accumulator bits
  function automatic longint hz_to_inc(input int hz, input int clk_hz, input int ph_w);
    longint num;
    num = (longint'(hz) << ph_w) + longint'(clk_hz / 2);
    return num / longint'(clk_hz);
  endfunction

  function automatic int dtmf_low_hz(input int code);
    case (code)
      1, 2, 3, 13:  return 697;
      4, 5, 6, 14:  return 770;
      7, 8, 9, 15:  return 852;
      default:      return 941;
    endcase
  endfunction

  function automatic int dtmf_high_hz(input int code);
    case (code)
      1, 4, 7, 11:  return 1209;
      2, 5, 8, 10:  return 1336;
      3, 6, 9, 12:  return 1477;
      default:      return 1633;
    endcase
  endfunction

  function automatic int single_hz(input int code);
    case (code)
      0:              return 1633;
      1, 4, 7:        return 1209;
      2, 5:           return 1336;
      3, 6:           return 1477;
      8, 9, 15:       return 852;
      10, 11, 12:     return 941;
      13:             return 697;
      default:        return 770;
    endcase
  endfunction

  // index = {bell, hi_rate, bit}
  function automatic int fsk_hz(input int idx);
    case (idx)
      0:       return 450;
      1:       return 390;
      2:       return 2100;
      3:       return 1300;
      4:       return 487;
      5:       return 387;
      6:       return 2200;
      default: return 1200;
    endcase
  endfunction

endpackage

// File: rtl/tone_inc_sel.sv
module tone_inc_sel
  import tone_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter int PH_W   = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bell_sel,
  input  logic            hi_rate,
  input  logic            fsk_en,
  input  logic            tx_bit,
  input  logic            tone_mode,
  input  logic            single_sel,
  input  logic            tone_en,
  input  logic [3:0]      tone_code,
  output logic [PH_W-1:0] inc_a,
  output logic [PH_W-1:0] inc_b,
  output logic            gate_q,
  output amp_sel_e        amp_q
);

  localparam int NCODE = 16;
  localparam int NFSK  = 8;

  logic [PH_W-1:0] low_tab  [NCODE];
  logic [PH_W-1:0] high_tab [NCODE];
  logic [PH_W-1:0] sgl_tab  [NCODE];
  logic [PH_W-1:0] fsk_tab  [NFSK];

  // constant increment tables, folded at elaboration
  for (genvar g = 0; g < NCODE; g++) begin : g_code_tab
    assign low_tab[g]  = PH_W'(hz_to_inc(dtmf_low_hz(g),  CLK_HZ, PH_W));
    assign high_tab[g] = PH_W'(hz_to_inc(dtmf_high_hz(g), CLK_HZ, PH_W));
    assign sgl_tab[g]  = PH_W'(hz_to_inc(single_hz(g),    CLK_HZ, PH_W));
  end
  for (genvar g = 0; g < NFSK; g++) begin : g_fsk_tab
    assign fsk_tab[g] = PH_W'(hz_to_inc(fsk_hz(g), CLK_HZ, PH_W));
  end

  logic [PH_W-1:0] inc_a_d, inc_b_d;
  logic            gate_d;
  amp_sel_e        amp_d;

  always_comb begin
    inc_a_d = fsk_tab[{bell_sel, hi_rate, tx_bit}];
    inc_b_d = '0;
    gate_d  = fsk_en;
    amp_d   = AMP_SEL_FSK;
    if (tone_mode) begin
      gate_d = tone_en;
      if (single_sel) begin
        inc_a_d = sgl_tab[tone_code];
        amp_d   = AMP_SEL_SGL;
      end else begin
        inc_a_d = low_tab[tone_code];
        inc_b_d = high_tab[tone_code];
        amp_d   = AMP_SEL_DUAL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_a  <= '0;
      inc_b  <= '0;
      gate_q <= 1'b0;
      amp_q  <= AMP_SEL_FSK;
    end else begin
      inc_a  <= inc_a_d;
      inc_b  <= inc_b_d;
      gate_q <= gate_d;
      amp_q  <= amp_d;
    end
  end

endmodule

// File: rtl/phase_sine_osc.sv
module phase_sine_osc #(
  parameter int PH_W  = 24,
  parameter int QA_W  = 6,
  parameter int ROM_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         inc,
  output logic signed [ROM_W:0]   sine_o
);

  localparam int  QDEPTH = 1 << QA_W;
  localparam real TWO_PI = 6.283185307179586;

  logic [PH_W-1:0]  acc;
  logic [ROM_W-1:0] rom [QDEPTH];
  logic [ROM_W-1:0] rom_q;
  logic             neg_q;
  logic [QA_W-1:0]  idx;
  logic [QA_W-1:0]  addr;

  // quarter-wave table, sampled at the centre of each step
  initial begin
    for (int i = 0; i < QDEPTH; i++) begin
      rom[i] = ROM_W'($rtoi($sin(TWO_PI * (real'(i) + 0.5) / real'(4 * QDEPTH))
                            * real'((1 << ROM_W) - 1) + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + inc;
  end

  assign idx  = acc[PH_W-3 -: QA_W];
  assign addr = acc[PH_W-2] ? ~idx : idx;

  always_ff @(posedge clk) begin
    rom_q <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= acc[PH_W-1];
  end

  assign sine_o = neg_q ? -$signed({1'b0, rom_q}) : $signed({1'b0, rom_q});

endmodule

// File: rtl/tone_synth.sv
module tone_synth
  import tone_pkg::*;
#(
  parameter int CLK_HZ  = 3579545,
  parameter int PH_W    = 24,
  parameter int QA_W    = 6,
  parameter int ROM_W   = 12,
  parameter int OUT_W   = 12,
  parameter int AMP_FSK = 1800,
  parameter int AMP_LO  = 1033,
  parameter int AMP_HI  = 1300,
  parameter int AMP_SGL = 1300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bell_sel,
  input  logic             hi_rate,
  input  logic             fsk_en,
  input  logic             tx_bit,
  input  logic             tone_mode,
  input  logic             single_sel,
  input  logic             tone_en,
  input  logic [3:0]       tone_code,
  output logic [OUT_W-1:0] sample_o
);

  localparam int NOSC   = 2;
  localparam int AMP_W  = OUT_W + 1;
  localparam int PROD_W = ROM_W + 1 + AMP_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_MAX = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_MIN = -SAT_MAX;

  logic [PH_W-1:0]        inc_a, inc_b;
  logic                   gate_p1, gate_p2, gate_p3;
  amp_sel_e               amp_p1, amp_p2, amp_p3;
  logic [PH_W-1:0]        inc_arr  [NOSC];
  logic signed [ROM_W:0]  sine_arr [NOSC];

  tone_inc_sel #(.CLK_HZ(CLK_HZ), .PH_W(PH_W)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .bell_sel   (bell_sel),
    .hi_rate    (hi_rate),
    .fsk_en     (fsk_en),
    .tx_bit     (tx_bit),
    .tone_mode  (tone_mode),
    .single_sel (single_sel),
    .tone_en    (tone_en),
    .tone_code  (tone_code),
    .inc_a      (inc_a),
    .inc_b      (inc_b),
    .gate_q     (gate_p1),
    .amp_q      (amp_p1)
  );

  assign inc_arr[0] = inc_a;
  assign inc_arr[1] = inc_b;

  for (genvar g = 0; g < NOSC; g++) begin : g_osc
    phase_sine_osc #(.PH_W(PH_W), .QA_W(QA_W), .ROM_W(ROM_W)) u_osc (
      .clk    (clk),
      .rst    (rst),
      .inc    (inc_arr[g]),
      .sine_o (sine_arr[g])
    );
  end

  // align gate and amplitude select with the table read stage
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_p2 <= 1'b0;
      gate_p3 <= 1'b0;
      amp_p2  <= AMP_SEL_FSK;
      amp_p3  <= AMP_SEL_FSK;
    end else begin
      gate_p2 <= gate_p1;
      gate_p3 <= gate_p2;
      amp_p2  <= amp_p1;
      amp_p3  <= amp_p2;
    end
  end

  logic signed [AMP_W-1:0]  amp_a;
  logic signed [PROD_W-1:0] prod_a, prod_b;
  logic signed [SUM_W-1:0]  sum_d;
  logic [OUT_W-1:0]         sat_d;

  always_comb begin
    case (amp_p3)
      AMP_SEL_SGL:  amp_a = AMP_W'(AMP_SGL);
      AMP_SEL_DUAL: amp_a = AMP_W'(AMP_LO);
      default:      amp_a = AMP_W'(AMP_FSK);
    endcase
    prod_a = (PROD_W'(sine_arr[0]) * PROD_W'(amp_a)) >>> ROM_W;
    prod_b = (PROD_W'(sine_arr[1]) * PROD_W'(AMP_W'(AMP_HI))) >>> ROM_W;
    sum_d  = SUM_W'(prod_a) + ((amp_p3 == AMP_SEL_DUAL) ? SUM_W'(prod_b) : '0);
    if (sum_d > SAT_MAX)      sat_d = OUT_W'(SAT_MAX);
    else if (sum_d < SAT_MIN) sat_d = OUT_W'(SAT_MIN);
    else                      sat_d = OUT_W'(sum_d);
  end

  always_ff @(posedge clk) begin
    if (rst)          sample_o <= '0;
    else if (gate_p3) sample_o <= sat_d;
    else              sample_o <= '0;
  end

endmodule

// File: rtl/tone_synth_chk.sv
module tone_synth_chk
  import tone_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter int PH_W   = 24,
  parameter int OUT_W  = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             bell_sel,
  input logic             hi_rate,
  input logic             fsk_en,
  input logic             tx_bit,
  input logic             tone_mode,
  input logic             tone_en,
  input logic [PH_W-1:0]  inc_a,
  input logic [OUT_W-1:0] sample_o
);

  function automatic logic [PH_W-1:0] fsk_expect(input logic b, input logic h, input logic m);
    int hz;
    if (!b) hz = h ? (m ? 1300 : 2100) : (m ? 390 : 450);
    else    hz = h ? (m ? 1200 : 2200) : (m ? 387 : 487);
    return PH_W'(hz_to_inc(hz, CLK_HZ, PH_W));
  endfunction

  logic [2:0] off_cnt;
  logic       port_off;

  assign port_off = tone_mode ? !tone_en : !fsk_en;

  always_ff @(posedge clk) begin
    if (rst || !port_off)   off_cnt <= '0;
    else if (off_cnt != 3'd7) off_cnt <= off_cnt + 3'd1;
  end

  p_mid_off_r3: assert property (@(posedge clk) disable iff (rst)
    (off_cnt >= 3'd4 && !tone_mode) |-> (sample_o == '0));

  p_gate_off_r6: assert property (@(posedge clk) disable iff (rst)
    (off_cnt >= 3'd4 && tone_mode) |-> (sample_o == '0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    sample_o != {1'b1, {(OUT_W-1){1'b0}}});

  p_fsk_freq_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tone_mode) && !$past(bell_sel))
    |-> (inc_a == fsk_expect(1'b0, $past(hi_rate), $past(tx_bit))));

  p_fsk_freq_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tone_mode) && $past(bell_sel))
    |-> (inc_a == fsk_expect(1'b1, $past(hi_rate), $past(tx_bit))));

  p_reset_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sample_o == '0));

endmodule

bind tone_synth tone_synth_chk #(.CLK_HZ(CLK_HZ), .PH_W(PH_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bell_sel  (bell_sel),
  .hi_rate   (hi_rate),
  .fsk_en    (fsk_en),
  .tx_bit    (tx_bit),
  .tone_mode (tone_mode),
  .tone_en   (tone_en),
  .inc_a     (inc_a),
  .sample_o  (sample_o)
);

// File: tb/tb_tone_synth.sv
module tb_tone_synth;

  localparam real CLK_F  = 3579545.0;
  localparam real PH_SC  = 16777216.0;
  localparam real TWO_PI = 6.283185307179586;
  localparam int  TOL    = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bell_sel = 0, hi_rate = 0, fsk_en = 0, tx_bit = 0;
  logic tone_mode = 0, single_sel = 0, tone_en = 0;
  logic [3:0] tone_code = 0;
  logic [11:0] sample_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  tone_synth dut (
    .clk(clk), .rst(rst), .bell_sel(bell_sel), .hi_rate(hi_rate),
    .fsk_en(fsk_en), .tx_bit(tx_bit), .tone_mode(tone_mode),
    .single_sel(single_sel), .tone_en(tone_en), .tone_code(tone_code),
    .sample_o(sample_o)
  );

  // ---- reference frequencies from the requirements ----
  function automatic int f_fsk(input logic b, input logic h, input logic m);
    if (b) return h ? (m ? 1200 : 2200) : (m ? 387 : 487);
    return h ? (m ? 1300 : 2100) : (m ? 390 : 450);
  endfunction

  function automatic int f_low(input int c);
    int row [16] = '{941,697,697,697,770,770,770,852,852,852,941,941,941,697,770,852};
    return row[c];
  endfunction

  function automatic int f_high(input int c);
    int col [16] = '{1633,1209,1336,1477,1209,1336,1477,1209,1336,1477,1336,1209,1477,1633,1633,1633};
    return col[c];
  endfunction

  function automatic int f_single(input int c);
    int s [16] = '{1633,1209,1336,1477,1209,1336,1477,1209,852,852,941,941,941,697,770,852};
    return s[c];
  endfunction

  function automatic int to_inc(input int hz);
    return $rtoi(real'(hz) * PH_SC / CLK_F + 0.5);
  endfunction

  // ---- phase model: increment applies from the second edge after a change (R7) ----
  int unsigned m_inc_a, m_inc_b, m_acc_a, m_acc_b;

  always @(posedge clk) begin
    if (rst) begin
      m_inc_a <= 0; m_inc_b <= 0; m_acc_a <= 0; m_acc_b <= 0;
    end else begin
      m_acc_a <= (m_acc_a + m_inc_a) & 32'hFF_FFFF;
      m_acc_b <= (m_acc_b + m_inc_b) & 32'hFF_FFFF;
      if (!tone_mode) begin
        m_inc_a <= to_inc(f_fsk(bell_sel, hi_rate, tx_bit));
        m_inc_b <= 0;
      end else if (single_sel) begin
        m_inc_a <= to_inc(f_single(tone_code));
        m_inc_b <= 0;
      end else begin
        m_inc_a <= to_inc(f_low(tone_code));
        m_inc_b <= to_inc(f_high(tone_code));
      end
    end
  end

  function automatic int expected_sample();
    real v;
    if (tone_mode && !tone_en) return 0;
    if (!tone_mode && !fsk_en) return 0;
    if (!tone_mode)
      v = 1800.0 * $sin(TWO_PI * real'(m_acc_a) / PH_SC);
    else if (single_sel)
      v = 1300.0 * $sin(TWO_PI * real'(m_acc_a) / PH_SC);
    else
      v = 1033.0 * $sin(TWO_PI * real'(m_acc_a) / PH_SC)
        + 1300.0 * $sin(TWO_PI * real'(m_acc_b) / PH_SC);
    if (v > 2047.0)  v = 2047.0;
    if (v < -2047.0) v = -2047.0;
    return $rtoi(v);
  endfunction

  function automatic string mode_tag();
    if (!tone_mode) return bell_sel ? "R2" : "R1";
    return single_sel ? "R5" : "R4";
  endfunction

  task automatic check_near(input string tag);
    int act, exp_v, d;
    act   = $signed(sample_o);
    exp_v = expected_sample();
    d     = act - exp_v;
    if (d < 0) d = -d;
    n_checks++;
    if (d > TOL) begin
      n_fail++;
      $display("FAIL %s: sample actual %0d expected %0d (+/-%0d)", tag, act, exp_v, TOL);
    end
  endtask

  task automatic check_exact(input string tag, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic run(input int n, input int bit_period, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bit_period > 0 && (i % bit_period) == 0) tx_bit = 1'($urandom);
      if ((i % 150) == 149) check_near(tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int sat_hits;
    void'($urandom(32'd1357));

    // R9: reset state
    repeat (4) @(negedge clk);
    check_exact("R9 during reset", $signed(sample_o), 0);
    rst = 1'b0;
    fsk_en = 1'b1;
    @(negedge clk);
    check_exact("R9 after release", $signed(sample_o), 0);

    // R1 directed: V.23 low rate mark/space
    run(3000, 300, "R1");
    hi_rate = 1'b1;
    run(3000, 100, "R1");

    // R2 directed: Bell 202 both rates
    bell_sel = 1'b1; hi_rate = 1'b0;
    run(3000, 300, "R2");
    hi_rate = 1'b1;
    run(3000, 100, "R2");

    // R7: rapid bit toggling, phase must stay continuous
    bell_sel = 1'b0;
    run(9000, 37, "R7");

    // R3: FSK disabled holds mid-level
    fsk_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i >= 6 && (i % 8) == 0) check_exact("R3 fsk disabled", $signed(sample_o), 0);
    end
    fsk_en = 1'b1;
    run(600, 0, "R3 resume");

    // R4: DTMF pairs, all codes directed
    tone_mode = 1'b1; tone_en = 1'b1; single_sel = 1'b0;
    for (int c = 0; c < 16; c++) begin
      tone_code = 4'(c);
      run(900, 0, "R4");
    end

    // R5: single tones, all codes directed
    single_sel = 1'b1;
    for (int c = 0; c < 16; c++) begin
      tone_code = 4'(c);
      run(900, 0, "R5");
    end

    // R6: tone gate off then on
    tone_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i >= 6 && (i % 8) == 0) check_exact("R6 tone gated", $signed(sample_o), 0);
    end
    tone_en = 1'b1;
    run(600, 0, "R6 resume");

    // R8: clipping on 941/1633 pair
    single_sel = 1'b0; tone_code = 4'd0;
    sat_hits = 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if ($signed(sample_o) == -2048) begin
        n_checks++; n_fail++;
        $display("FAIL R8: actual -2048 expected within +/-2047");
      end
      if ($signed(sample_o) == 2047 || $signed(sample_o) == -2047) sat_hits++;
      if ((i % 150) == 149) check_near("R8");
    end
    n_checks++;
    if (sat_hits == 0) begin
      n_fail++;
      $display("FAIL R8: clip count actual 0 expected > 0");
    end

    // random mix of modes
    for (int s = 0; s < 24; s++) begin
      tone_mode  = ($urandom % 3) == 0;
      single_sel = 1'($urandom);
      tone_code  = 4'($urandom);
      bell_sel   = 1'($urandom);
      hi_rate    = 1'($urandom);
      fsk_en     = 1'b1;
      tone_en    = 1'b1;
      run(2500, tone_mode ? 0 : (hi_rate ? 60 + ($urandom % 40) : 400), mode_tag());
    end

    finish_run();
  end

endmodule